// File: doc/BRIEF.md
# Inter-Stage Pipeline Register with Hold and Flush

This block is the register that sits between two adjacent stages of a five-stage in-order processor. On every rising clock edge it captures a 16-bit instruction word and a parameterised set of equal-width data lanes from the upstream stage. The lanes carry the operands, the immediate, the prediction bit and the result. The captured values drive the downstream stage directly from flops. One module serves every stage boundary: the number of lanes and their width are parameters.

Two control inputs change what is captured.

- **Hold** freezes the register, so the downstream stage keeps seeing the same instruction.
- **Flush** loads a no-operation word and clears every data lane, which discards the partial work in that slot. A flush overrides a hold asserted in the same cycle.

Synchronous reset loads the same empty state as a flush, so the pipeline starts with no instructions in flight. To insert a true bubble, a controller holds every register upstream of a chosen boundary and flushes the register at that boundary. The stalled instruction then follows the bubble one cycle later.

Top module: `pipe_stage_reg`

## Requirements
- R1: While `rst` is high at a rising edge, the instruction output becomes the NOP word and every data lane becomes zero, whatever `hold` and `flush` are.
- R2: With `hold` and `flush` both low, the instruction and all data lanes present at a rising edge appear on the outputs after that edge.
- R3: With `hold` high and `flush` low, the outputs keep their previous values across the edge, whatever the inputs carry.
- R4: With `flush` high, the instruction output becomes the NOP word. This word has opcode 13 in bits [15:12] and zeros in bits [11:0], which is 16'hD000 at the default width.
- R5: With `flush` high, every data lane output becomes zero.
- R6: With `hold` and `flush` both high, the flush behaviour of R4 and R5 applies and the hold is ignored.
- R7: Data lane k occupies bits [k*LANE_W +: LANE_W] of both the input and the output. Each lane is captured into the same position, with no crossing between lanes.
- R8: When two registers are chained, holding the upstream one while flushing the downstream one puts a NOP downstream and keeps the upstream instruction. When both are then released, the kept instruction moves downstream on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the empty state |
| hold | input | 1 | Keep the current contents |
| flush | input | 1 | Load the NOP word and zero the lanes; overrides hold |
| ins_d | input | INS_W | Instruction word from the upstream stage |
| lane_d | input | LANES*LANE_W | Packed data lanes from the upstream stage |
| ins_q | output | INS_W | Registered instruction word |
| lane_q | output | LANES*LANE_W | Registered packed data lanes |

## Verification
The bench sweeps every value of a small two-lane, four-bit configuration against all four combinations of hold and flush, and it chains a second instance to build a true bubble.

The sweep targets several specific faults:

- **Hold and flush in the same cycle.** A design that gave hold priority would pass a stale instruction downstream instead of the NOP.
- **Flushing only the instruction.** A design that cleared the instruction but not the lanes would leave live operands behind a NOP.
- **Wrong NOP encoding.** A design that placed the opcode at the wrong bits would produce a word other than 16'hD000.
- **Lane mapping.** Distinct values in each lane reveal any swap between lanes.
- **Reset while hold is asserted.** This case reveals a reset that is gated by hold.

// File: rtl/psr_pkg.sv
package psr_pkg;
  // Action taken by a pipeline register at the next rising edge.
  typedef enum logic [1:0] {
    ACT_LOAD  = 2'd0,
    ACT_HOLD  = 2'd1,
    ACT_CLEAR = 2'd2
  } psr_act_e;

  localparam int unsigned DEF_INS_W  = 16;
  localparam int unsigned DEF_OPC_W  = 4;
  localparam int unsigned DEF_NOP_OP = 13;
endpackage

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic     rst,
  input  logic     hold,
  input  logic     flush,
  output psr_act_e act
);
  // Priority: reset, then flush, then hold, then load.
  always_comb begin
    if (rst || flush) act = ACT_CLEAR;
    else if (hold)    act = ACT_HOLD;
    else              act = ACT_LOAD;
  end
endmodule

// File: rtl/psr_ins_reg.sv
module psr_ins_reg
  import psr_pkg::*;
#(
  parameter int unsigned INS_W  = DEF_INS_W,
  parameter int unsigned OPC_W  = DEF_OPC_W,
  parameter int unsigned NOP_OP = DEF_NOP_OP
) (
  input  logic             clk,
  input  logic             rst,
  input  psr_act_e         act,
  input  logic [INS_W-1:0] d,
  output logic [INS_W-1:0] q
);
  localparam int unsigned     OPC_LSB  = INS_W - OPC_W;
  localparam logic [INS_W-1:0] NOP_WORD = INS_W'(NOP_OP) << OPC_LSB;

  always_ff @(posedge clk) begin
    case (act)
      ACT_CLEAR: q <= NOP_WORD;
      ACT_HOLD:  q <= q;
      default:   q <= d;
    endcase
  end

  // R2
  ins_load_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_LOAD) |=> (q == $past(d)));

  // R4
  ins_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_CLEAR) |=> (q[INS_W-1:OPC_LSB] == OPC_W'(NOP_OP) && q[OPC_LSB-1:0] == '0));
endmodule

// File: rtl/psr_lane_reg.sv
module psr_lane_reg
  import psr_pkg::*;
#(
  parameter int unsigned LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  psr_act_e          act,
  input  logic [LANE_W-1:0] d,
  output logic [LANE_W-1:0] q
);
  always_ff @(posedge clk) begin
    case (act)
      ACT_CLEAR: q <= '0;
      ACT_HOLD:  q <= q;
      default:   q <= d;
    endcase
  end

  // R5
  lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_CLEAR) |=> (q == '0));

  // R7
  lane_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_LOAD) |=> (q == $past(d)));
endmodule

// File: rtl/pipe_stage_reg.sv
module pipe_stage_reg
  import psr_pkg::*;
#(
  parameter int unsigned INS_W  = DEF_INS_W,
  parameter int unsigned OPC_W  = DEF_OPC_W,
  parameter int unsigned NOP_OP = DEF_NOP_OP,
  parameter int unsigned LANE_W = 16,
  parameter int unsigned LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hold,
  input  logic                    flush,
  input  logic [INS_W-1:0]        ins_d,
  input  logic [LANES*LANE_W-1:0] lane_d,
  output logic [INS_W-1:0]        ins_q,
  output logic [LANES*LANE_W-1:0] lane_q
);
  localparam int unsigned     BUS_W    = LANES * LANE_W;
  localparam logic [INS_W-1:0] NOP_WORD = INS_W'(NOP_OP) << (INS_W - OPC_W);

  psr_act_e act;

  psr_ctrl u_ctrl (
    .rst   (rst),
    .hold  (hold),
    .flush (flush),
    .act   (act)
  );

  psr_ins_reg #(
    .INS_W  (INS_W),
    .OPC_W  (OPC_W),
    .NOP_OP (NOP_OP)
  ) u_ins (
    .clk (clk),
    .rst (rst),
    .act (act),
    .d   (ins_d),
    .q   (ins_q)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    psr_lane_reg #(.LANE_W(LANE_W)) u_lane (
      .clk (clk),
      .rst (rst),
      .act (act),
      .d   (lane_d[k*LANE_W +: LANE_W]),
      .q   (lane_q[k*LANE_W +: LANE_W])
    );
  end

  // R3
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !flush) |=> ($stable(ins_q) && $stable(lane_q)));

  // R6
  flush_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && flush) |=> (ins_q == NOP_WORD && lane_q == BUS_W'(0)));

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_seen === 1'b1)
      reset_empty_chk: assert (ins_q == NOP_WORD && lane_q == BUS_W'(0));
  end
endmodule

// File: tb/pipe_stage_reg_bench.sv
module pipe_stage_reg_bench;
  localparam int INS_W  = 16;
  localparam int LANE_W = 4;
  localparam int LANES  = 2;
  localparam int BW     = LANE_W * LANES;
  localparam logic [15:0] NOP = 16'hD000;

  logic clk = 1'b0;
  logic rst, hold, flush, dn_hold, dn_flush;
  logic [INS_W-1:0] ins_d, ins_q, dn_ins_q;
  logic [BW-1:0]    lane_d, lane_q, dn_lane_q;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pipe_stage_reg #(.LANE_W(LANE_W), .LANES(LANES)) u_pipe_stage_reg (
    .clk(clk), .rst(rst), .hold(hold), .flush(flush),
    .ins_d(ins_d), .lane_d(lane_d), .ins_q(ins_q), .lane_q(lane_q));

  pipe_stage_reg #(.LANE_W(LANE_W), .LANES(LANES)) u_down (
    .clk(clk), .rst(rst), .hold(dn_hold), .flush(dn_flush),
    .ins_d(ins_q), .lane_d(lane_q), .ins_q(dn_ins_q), .lane_q(dn_lane_q));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0]   e_ins;
    logic [BW-1:0] e_lane;
    rst = 1'b1; hold = 1'b1; flush = 1'b0; dn_hold = 1'b0; dn_flush = 1'b0;
    ins_d = 16'h1234; lane_d = 8'hA5;
    // R1: reset wins over hold
    @(posedge clk); #2;
    chk("R1 ins", 32'(ins_q), 32'(NOP));
    chk("R1 lane", 32'(lane_q), 32'h0);
    @(posedge clk); #2;
    chk("R1 down ins", 32'(dn_ins_q), 32'(NOP));
    @(negedge clk); rst = 1'b0; hold = 1'b0;
    e_ins = NOP; e_lane = '0;

    for (int v = 0; v < 256; v++) begin
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        hold   = c[0];
        flush  = c[1];
        ins_d  = {v[7:0], ~v[7:0]};
        lane_d = v[7:0] ^ 8'(c * 37);
        if (flush) begin
          e_ins = NOP; e_lane = '0;
        end else if (!hold) begin
          e_ins = ins_d; e_lane = lane_d;
        end
        @(posedge clk); #2;
        case (c)
          0: begin
            chk("R2 ins", 32'(ins_q), 32'(e_ins));
            chk("R7 lane0", 32'(lane_q[3:0]), 32'(lane_d[3:0]));
            chk("R7 lane1", 32'(lane_q[7:4]), 32'(lane_d[7:4]));
          end
          1: begin
            chk("R3 ins", 32'(ins_q), 32'(e_ins));
            chk("R3 lane", 32'(lane_q), 32'(e_lane));
          end
          2: begin
            chk("R4 ins", 32'(ins_q), 32'(NOP));
            chk("R5 lane", 32'(lane_q), 32'h0);
          end
          default: begin
            chk("R6 ins", 32'(ins_q), 32'(NOP));
            chk("R6 lane", 32'(lane_q), 32'h0);
          end
        endcase
      end
    end

    // R8: true bubble across two chained registers
    @(negedge clk); hold = 1'b0; flush = 1'b0; ins_d = 16'h4AAA; lane_d = 8'h3C;
    @(negedge clk); hold = 1'b1; dn_flush = 1'b1; ins_d = 16'h5BBB; lane_d = 8'h77;
    @(posedge clk); #2;
    chk("R8 up held", 32'(ins_q), 32'h4AAA);
    chk("R8 down nop", 32'(dn_ins_q), 32'(NOP));
    chk("R8 down lane", 32'(dn_lane_q), 32'h0);
    @(negedge clk); hold = 1'b0; dn_flush = 1'b0; ins_d = 16'h6CCC; lane_d = 8'h11;
    @(posedge clk); #2;
    chk("R8 up new", 32'(ins_q), 32'h6CCC);
    chk("R8 down follows", 32'(dn_ins_q), 32'h4AAA);
    chk("R8 down lane", 32'(dn_lane_q), 32'h3C);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule